// File: doc/BRIEF.md
# AXI4-Lite Control and Status Register Bank

This block is a small AXI4-Lite slave that gives software three 32-bit registers for a peripheral core. The register window begins at a configurable base address, and every access is decoded by its offset from that base. The control register and the data register can be read and written from the bus. Their current values are driven out to the core. The status register cannot be written; it reports a value that the core supplies.

The core runs on its own clock. Values going to the core and the status value coming back each pass through a chain of synchronizer flops, two stages by default. Two bus events are also delivered to the core as single-cycle pulses in the core clock domain: a successful write of control, and an accepted read of status. The core can use the status-read pulse, for example, to clear sticky flags. Each event flips a toggle in the bus domain. The core side detects the edge of that toggle, so no event is lost when the two clocks differ in rate.

Top module: `axil_csr_bank`

## Requirements
- R1: While aresetn is low and after its release, bvalid and rvalid are 0, awready, wready and arready are 1, and control, data, ctrlOut and dataOut are all zero.
- R2: Decoding uses the offset of the address from BASE_ADDR (default 0x00002000). Offset 0x00 is control, 0x04 is status and 0x08 is data. Every other offset is unmapped, including unaligned offsets and addresses below the base.
- R3: A write to control merges wdata byte by byte: wstrb bit i selects byte i (bits 8i+7..8i). Reading control returns the merged value with response OKAY (2'b00).
- R4: The data register is read-write with the same byte masking as control, and writing or reading it produces no pulse on either core-side pulse output.
- R5: A read of offset 0x04 returns the synchronized statIn value with OKAY.
- R6: A write to status or to an unmapped offset responds SLVERR (2'b10) and changes neither register nor ctrlOut/dataOut, and it produces no pulse. A read of an unmapped offset returns 0 with SLVERR.
- R7: The write address and the write data may be accepted in either order or in the same cycle. bvalid rises only after both have been accepted and stays high until bready. While bvalid is high, awready and wready are low.
- R8: rvalid stays high with rdata and rresp stable until rready, and arready is low while rvalid is high.
- R9: Each successful control write produces exactly one coreClk-cycle pulse on ctrlWrPulse, and ctrlOut then carries the new control value.
- R10: Each accepted read of status produces exactly one coreClk-cycle pulse on statRdPulse. Reads of other offsets produce none.
- R11: ctrlOut and dataOut follow the bus-side registers through SYNC_STAGES core-clock flops, and statIn reaches the bus side through SYNC_STAGES bus-clock flops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aclk | input | 1 | Bus clock |
| aresetn | input | 1 | Bus-domain reset, active low |
| awaddr | input | ADDR_W | Write address |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address ready |
| wdata | input | DATA_W | Write data |
| wstrb | input | DATA_W/8 | Write byte enables |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data ready |
| bresp | output | 2 | Write response |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response ready |
| araddr | input | ADDR_W | Read address |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address ready |
| rdata | output | DATA_W | Read data |
| rresp | output | 2 | Read response |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Read data ready |
| coreClk | input | 1 | Core clock |
| coreRstN | input | 1 | Core-domain reset, active low |
| ctrlOut | output | DATA_W | Control value in the core domain |
| ctrlWrPulse | output | 1 | One core cycle per successful control write |
| dataOut | output | DATA_W | Data value in the core domain |
| statIn | input | DATA_W | Status value from the core |
| statRdPulse | output | 1 | One core cycle per status read |

## Verification
The hardest situation to reach is a write whose address and data phases are split across cycles, in either order, while the manager holds bready low. The bench drives each write channel from its own step, so it can present data before the address, the address before the data, or both together. It then keeps bready low for several cycles and checks that bvalid stays up and that both ready outputs stay down. Because the two clocks differ, the pulse and value checks wait out the synchronizer latency. They count pulses on the core-clock falling edge, so each pulse is counted exactly once.

// File: rtl/csr_bank_pkg.sv
package csr_bank_pkg;

  localparam int OFF_CTRL = 'h00;
  localparam int OFF_STAT = 'h04;
  localparam int OFF_DATA = 'h08;

  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_SLVERR = 2'b10;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_STAT = 2'd2,
    SEL_DATA = 2'd3
  } regSel_t;

  // Handshake events the control FSM hands to the datapath.
  typedef struct packed {
    logic wrCommit;
    logic rdCommit;
  } csrStrobes_t;

endpackage

// File: rtl/csr_bank_sync.sv
module csr_bank_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[0] <= '0;
        else       chain[0] <= d;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[s] <= '0;
        else       chain[s] <= chain[s-1];
      end
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/csr_bank_evt_xing.sv
module csr_bank_evt_xing #(
  parameter int STAGES = 2
) (
  input  logic dstClk,
  input  logic dstRstN,
  input  logic srcToggle,
  output logic dstPulse
);

  logic togSynced;
  logic togPrev;

  csr_bank_sync #(.WIDTH(1), .STAGES(STAGES)) u_togSync (
    .clk  (dstClk),
    .rstN (dstRstN),
    .d    (srcToggle),
    .q    (togSynced)
  );

  always_ff @(posedge dstClk or negedge dstRstN) begin
    if (!dstRstN) begin
      togPrev  <= 1'b0;
      dstPulse <= 1'b0;
    end else begin
      togPrev  <= togSynced;
      dstPulse <= togSynced ^ togPrev;
    end
  end

endmodule

// File: rtl/csr_bank_ctrl.sv
module csr_bank_ctrl
  import csr_bank_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic              awvalid,
  output logic              awready,
  input  logic [DATA_W-1:0] wdata,
  input  logic [STRB_W-1:0] wstrb,
  input  logic              wvalid,
  output logic              wready,
  output logic [1:0]        bresp,
  output logic              bvalid,
  input  logic              bready,
  input  logic              arvalid,
  output logic              arready,
  output logic              rvalid,
  input  logic              rready,
  input  logic              wrOk,
  output csrStrobes_t       stb,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic [STRB_W-1:0] wrStrb
);

  logic awHeld, wHeld;
  logic bvalidQ, rvalidQ;
  logic [1:0] brespQ;

  assign awready = !awHeld && !bvalidQ;
  assign wready  = !wHeld && !bvalidQ;
  assign arready = !rvalidQ;

  assign stb.wrCommit = awHeld && wHeld;
  assign stb.rdCommit = arvalid && !rvalidQ;

  // Address and data channels are captured independently.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      awHeld <= 1'b0;
      wrAddr <= '0;
    end else if (stb.wrCommit) begin
      awHeld <= 1'b0;
    end else if (awvalid && awready) begin
      awHeld <= 1'b1;
      wrAddr <= awaddr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wHeld  <= 1'b0;
      wrData <= '0;
      wrStrb <= '0;
    end else if (stb.wrCommit) begin
      wHeld <= 1'b0;
    end else if (wvalid && wready) begin
      wHeld  <= 1'b1;
      wrData <= wdata;
      wrStrb <= wstrb;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bvalidQ <= 1'b0;
      brespQ  <= RESP_OKAY;
    end else if (stb.wrCommit) begin
      bvalidQ <= 1'b1;
      brespQ  <= wrOk ? RESP_OKAY : RESP_SLVERR;
    end else if (bvalidQ && bready) begin
      bvalidQ <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 rvalidQ <= 1'b0;
    else if (stb.rdCommit)     rvalidQ <= 1'b1;
    else if (rvalidQ && rready) rvalidQ <= 1'b0;
  end

  assign bvalid = bvalidQ;
  assign bresp  = brespQ;
  assign rvalid = rvalidQ;

endmodule

// File: rtl/csr_bank_dp.sv
module csr_bank_dp
  import csr_bank_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h0000_2000,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  csrStrobes_t       stb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [STRB_W-1:0] wrStrb,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] statSynced,
  output logic              wrOk,
  output logic [DATA_W-1:0] rdData,
  output logic [1:0]        rdResp,
  output logic [DATA_W-1:0] ctrlQ,
  output logic [DATA_W-1:0] dataQ,
  output logic              ctrlTog,
  output logic              statTog
);

  function automatic regSel_t selOf(input logic [ADDR_W-1:0] off);
    if (off == ADDR_W'(OFF_CTRL)) return SEL_CTRL;
    if (off == ADDR_W'(OFF_STAT)) return SEL_STAT;
    if (off == ADDR_W'(OFF_DATA)) return SEL_DATA;
    return SEL_NONE;
  endfunction

  logic [ADDR_W-1:0] wrOff, rdOff;
  regSel_t wrSel, rdSel;
  logic [DATA_W-1:0] ctrlNext, dataNext;

  assign wrOff = wrAddr - BASE_ADDR;
  assign rdOff = rdAddr - BASE_ADDR;
  assign wrSel = selOf(wrOff);
  assign rdSel = selOf(rdOff);
  assign wrOk  = (wrSel == SEL_CTRL) || (wrSel == SEL_DATA);

  for (genvar b = 0; b < STRB_W; b++) begin : g_lane
    assign ctrlNext[b*8 +: 8] = wrStrb[b] ? wrData[b*8 +: 8] : ctrlQ[b*8 +: 8];
    assign dataNext[b*8 +: 8] = wrStrb[b] ? wrData[b*8 +: 8] : dataQ[b*8 +: 8];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ   <= '0;
      dataQ   <= '0;
      ctrlTog <= 1'b0;
    end else if (stb.wrCommit) begin
      case (wrSel)
        SEL_CTRL: begin
          ctrlQ   <= ctrlNext;
          ctrlTog <= ~ctrlTog;
        end
        SEL_DATA: dataQ <= dataNext;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rdResp  <= RESP_OKAY;
      statTog <= 1'b0;
    end else if (stb.rdCommit) begin
      rdResp <= RESP_OKAY;
      case (rdSel)
        SEL_CTRL: rdData <= ctrlQ;
        SEL_DATA: rdData <= dataQ;
        SEL_STAT: begin
          rdData  <= statSynced;
          statTog <= ~statTog;
        end
        default: begin
          rdData <= '0;
          rdResp <= RESP_SLVERR;
        end
      endcase
    end
  end

endmodule

// File: rtl/axil_csr_bank.sv
module axil_csr_bank
  import csr_bank_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h0000_2000,
  parameter int SYNC_STAGES = 2,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic              aclk,
  input  logic              aresetn,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic              awvalid,
  output logic              awready,
  input  logic [DATA_W-1:0] wdata,
  input  logic [STRB_W-1:0] wstrb,
  input  logic              wvalid,
  output logic              wready,
  output logic [1:0]        bresp,
  output logic              bvalid,
  input  logic              bready,
  input  logic [ADDR_W-1:0] araddr,
  input  logic              arvalid,
  output logic              arready,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        rresp,
  output logic              rvalid,
  input  logic              rready,
  input  logic              coreClk,
  input  logic              coreRstN,
  output logic [DATA_W-1:0] ctrlOut,
  output logic              ctrlWrPulse,
  output logic [DATA_W-1:0] dataOut,
  input  logic [DATA_W-1:0] statIn,
  output logic              statRdPulse
);

  csrStrobes_t       stb;
  logic              wrOk;
  logic [ADDR_W-1:0] wrAddr;
  logic [DATA_W-1:0] wrData;
  logic [STRB_W-1:0] wrStrb;
  logic [DATA_W-1:0] ctrlQ, dataQ, statSynced;
  logic              ctrlTog, statTog;

  csr_bank_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(aclk), .rstN(aresetn),
    .awaddr(awaddr), .awvalid(awvalid), .awready(awready),
    .wdata(wdata), .wstrb(wstrb), .wvalid(wvalid), .wready(wready),
    .bresp(bresp), .bvalid(bvalid), .bready(bready),
    .arvalid(arvalid), .arready(arready),
    .rvalid(rvalid), .rready(rready),
    .wrOk(wrOk), .stb(stb),
    .wrAddr(wrAddr), .wrData(wrData), .wrStrb(wrStrb)
  );

  csr_bank_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_ADDR(BASE_ADDR)) u_dp (
    .clk(aclk), .rstN(aresetn), .stb(stb),
    .wrAddr(wrAddr), .wrData(wrData), .wrStrb(wrStrb),
    .rdAddr(araddr), .statSynced(statSynced),
    .wrOk(wrOk), .rdData(rdata), .rdResp(rresp),
    .ctrlQ(ctrlQ), .dataQ(dataQ),
    .ctrlTog(ctrlTog), .statTog(statTog)
  );

  csr_bank_sync #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES)) u_ctrlSync (
    .clk(coreClk), .rstN(coreRstN), .d(ctrlQ), .q(ctrlOut)
  );

  csr_bank_sync #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES)) u_dataSync (
    .clk(coreClk), .rstN(coreRstN), .d(dataQ), .q(dataOut)
  );

  csr_bank_sync #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES)) u_statSync (
    .clk(aclk), .rstN(aresetn), .d(statIn), .q(statSynced)
  );

  csr_bank_evt_xing #(.STAGES(SYNC_STAGES)) u_ctrlEvt (
    .dstClk(coreClk), .dstRstN(coreRstN), .srcToggle(ctrlTog), .dstPulse(ctrlWrPulse)
  );

  csr_bank_evt_xing #(.STAGES(SYNC_STAGES)) u_statEvt (
    .dstClk(coreClk), .dstRstN(coreRstN), .srcToggle(statTog), .dstPulse(statRdPulse)
  );

endmodule

// File: rtl/axil_csr_bank_chk.sv
module axil_csr_bank_chk
  import csr_bank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              aclk,
  input logic              aresetn,
  input logic              awready,
  input logic              wready,
  input logic              bvalid,
  input logic              bready,
  input logic [1:0]        bresp,
  input logic              arready,
  input logic              rvalid,
  input logic              rready,
  input logic [DATA_W-1:0] rdata,
  input logic [1:0]        rresp,
  input logic [DATA_W-1:0] ctrlQ,
  input logic [DATA_W-1:0] dataQ
);

  AST_BVALID_HOLD: assert property (@(posedge aclk) disable iff (!aresetn)
    bvalid && !bready |=> bvalid); // R7

  AST_WRITE_BLOCKED: assert property (@(posedge aclk) disable iff (!aresetn)
    bvalid |-> !awready && !wready); // R7

  AST_RVALID_HOLD: assert property (@(posedge aclk) disable iff (!aresetn)
    rvalid && !rready |=> rvalid && $stable(rdata) && $stable(rresp)); // R8

  AST_READ_BLOCKED: assert property (@(posedge aclk) disable iff (!aresetn)
    rvalid |-> !arready); // R8

  AST_ERR_READ_ZERO: assert property (@(posedge aclk) disable iff (!aresetn)
    rvalid && rresp == RESP_SLVERR |-> rdata == '0); // R6

  AST_ERR_WRITE_NOCHANGE: assert property (@(posedge aclk) disable iff (!aresetn)
    $rose(bvalid) && bresp == RESP_SLVERR |-> $stable(ctrlQ) && $stable(dataQ)); // R6

endmodule

bind axil_csr_bank axil_csr_bank_chk #(.DATA_W(DATA_W)) u_chk (
  .aclk(aclk), .aresetn(aresetn), .awready(awready), .wready(wready),
  .bvalid(bvalid), .bready(bready), .bresp(bresp), .arready(arready),
  .rvalid(rvalid), .rready(rready), .rdata(rdata), .rresp(rresp),
  .ctrlQ(ctrlQ), .dataQ(dataQ)
);

// File: tb/axil_csr_bank_bench.sv
`timescale 1ns/1ps
module axil_csr_bank_bench;

  logic        aclk = 0, coreClk = 0;
  logic        aresetn = 0, coreRstN = 0;
  logic [31:0] awaddr = 0, wdata = 0, araddr = 0, statIn = 0;
  logic [3:0]  wstrb = 0;
  logic        awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
  logic        awready, wready, bvalid, arready, rvalid, ctrlWrPulse, statRdPulse;
  logic [1:0]  bresp, rresp;
  logic [31:0] rdata, ctrlOut, dataOut;

  always #2.5 aclk = ~aclk;
  always #3.5 coreClk = ~coreClk;

  axil_csr_bank u_axil_csr_bank (
    .aclk(aclk), .aresetn(aresetn),
    .awaddr(awaddr), .awvalid(awvalid), .awready(awready),
    .wdata(wdata), .wstrb(wstrb), .wvalid(wvalid), .wready(wready),
    .bresp(bresp), .bvalid(bvalid), .bready(bready),
    .araddr(araddr), .arvalid(arvalid), .arready(arready),
    .rdata(rdata), .rresp(rresp), .rvalid(rvalid), .rready(rready),
    .coreClk(coreClk), .coreRstN(coreRstN),
    .ctrlOut(ctrlOut), .ctrlWrPulse(ctrlWrPulse), .dataOut(dataOut),
    .statIn(statIn), .statRdPulse(statRdPulse)
  );

  int nChecks = 0, nFail = 0;
  int ctrlPulses = 0, statPulses = 0;

  always @(negedge coreClk) begin
    if (ctrlWrPulse) ctrlPulses++;
    if (statRdPulse) statPulses++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [31:0] a, input logic [31:0] d, input logic [3:0] s,
                         input int order, output logic [1:0] resp);
    if (order == 0) begin
      awaddr = a; wdata = d; wstrb = s; awvalid = 1; wvalid = 1;
      while (!(awready && wready)) @(negedge aclk);
      @(negedge aclk); awvalid = 0; wvalid = 0;
    end else if (order == 1) begin
      awaddr = a; awvalid = 1;
      while (!awready) @(negedge aclk);
      @(negedge aclk); awvalid = 0;
      repeat (2) @(negedge aclk);
      wdata = d; wstrb = s; wvalid = 1;
      while (!wready) @(negedge aclk);
      @(negedge aclk); wvalid = 0;
    end else begin
      wdata = d; wstrb = s; wvalid = 1;
      while (!wready) @(negedge aclk);
      @(negedge aclk); wvalid = 0;
      repeat (2) @(negedge aclk);
      awaddr = a; awvalid = 1;
      while (!awready) @(negedge aclk);
      @(negedge aclk); awvalid = 0;
    end
    bready = 1;
    while (!bvalid) @(negedge aclk);
    resp = bresp;
    @(negedge aclk); bready = 0;
  endtask

  task automatic doRead(input logic [31:0] a, output logic [31:0] d, output logic [1:0] resp);
    araddr = a; arvalid = 1;
    while (!arready) @(negedge aclk);
    @(negedge aclk); arvalid = 0; rready = 1;
    while (!rvalid) @(negedge aclk);
    d = rdata; resp = rresp;
    @(negedge aclk); rready = 0;
  endtask

  typedef struct packed {
    logic        isWr;
    logic [31:0] addr;
    logic [31:0] data;   // write data or expected read data
    logic [3:0]  strb;
    logic [1:0]  resp;
  } vec_t;

  localparam vec_t VECS [13] = '{
    '{1'b1, 32'h2000, 32'h1122_3344, 4'hF, 2'b00}, // R3 full control write
    '{1'b0, 32'h2000, 32'h1122_3344, 4'h0, 2'b00}, // R3 readback
    '{1'b1, 32'h2008, 32'hA5A5_A5A5, 4'hF, 2'b00}, // R4 data write
    '{1'b1, 32'h2008, 32'h0000_00FF, 4'h1, 2'b00}, // R4 byte 0 only
    '{1'b0, 32'h2008, 32'hA5A5_A5FF, 4'h0, 2'b00}, // R4 merged readback
    '{1'b1, 32'h2004, 32'hFFFF_FFFF, 4'hF, 2'b10}, // R6 write to status
    '{1'b1, 32'h200C, 32'hFFFF_FFFF, 4'hF, 2'b10}, // R6 unmapped write
    '{1'b0, 32'h200C, 32'h0000_0000, 4'h0, 2'b10}, // R6 unmapped read
    '{1'b0, 32'h1FFC, 32'h0000_0000, 4'h0, 2'b10}, // R2 below base
    '{1'b1, 32'h2000, 32'hCAFE_BABE, 4'hC, 2'b00}, // R3 upper bytes only
    '{1'b0, 32'h2000, 32'hCAFE_3344, 4'h0, 2'b00}, // R3 merged readback
    '{1'b0, 32'h2008, 32'hA5A5_A5FF, 4'h0, 2'b00}, // R6 data untouched
    '{1'b0, 32'h2002, 32'h0000_0000, 4'h0, 2'b10}  // R2 unaligned offset
  };

  initial begin
    logic [1:0]  resp;
    logic [31:0] rd;
    int expCtrlPulses;

    repeat (4) @(negedge aclk);
    // R1 reset state
    chk("R1 bvalid", 32'(bvalid), 0);
    chk("R1 rvalid", 32'(rvalid), 0);
    chk("R1 ready", {29'b0, awready, wready, arready}, 32'h7);
    aresetn = 1; coreRstN = 1;
    repeat (8) @(negedge aclk);
    chk("R1 ctrlOut", ctrlOut, 0);
    chk("R1 dataOut", dataOut, 0);
    doRead(32'h2000, rd, resp);
    chk("R1 control reads zero", rd, 0);

    expCtrlPulses = 0;
    foreach (VECS[i]) begin
      if (VECS[i].isWr) begin
        doWrite(VECS[i].addr, VECS[i].data, VECS[i].strb, 0, resp);
        chk($sformatf("vec%0d R7 bresp", i), 32'(resp), 32'(VECS[i].resp));
        if (VECS[i].addr == 32'h2000 && VECS[i].resp == 2'b00) expCtrlPulses++;
      end else begin
        doRead(VECS[i].addr, rd, resp);
        chk($sformatf("vec%0d R2 rresp", i), 32'(resp), 32'(VECS[i].resp));
        chk($sformatf("vec%0d R3 rdata", i), rd, VECS[i].data);
      end
    end

    repeat (12) @(negedge aclk);
    chk("R11 ctrlOut follows", ctrlOut, 32'hCAFE_3344);
    chk("R11 dataOut follows", dataOut, 32'hA5A5_A5FF);
    chk("R9 control pulse count", 32'(ctrlPulses), 32'(expCtrlPulses));
    chk("R10 no status pulse yet", 32'(statPulses), 0);

    // R7 data before address, then address before data
    doWrite(32'h2000, 32'h0000_AAAA, 4'hF, 2, resp);
    chk("R7 data-first bresp", 32'(resp), 0);
    doWrite(32'h2008, 32'h1234_5678, 4'hF, 1, resp);
    chk("R7 addr-first bresp", 32'(resp), 0);
    doRead(32'h2000, rd, resp);
    chk("R7 data-first value", rd, 32'h0000_AAAA);
    doRead(32'h2008, rd, resp);
    chk("R7 addr-first value", rd, 32'h1234_5678);
    repeat (12) @(negedge aclk);
    chk("R9 pulse after split write", 32'(ctrlPulses), 32'(expCtrlPulses + 1));
    chk("R9 ctrlOut new value", ctrlOut, 32'h0000_AAAA);
    chk("R4 data write made no pulse", 32'(statPulses), 0);

    // R7 bvalid held while bready low
    awaddr = 32'h2008; wdata = 32'h0BAD_F00D; wstrb = 4'hF; awvalid = 1; wvalid = 1;
    @(negedge aclk); awvalid = 0; wvalid = 0;
    while (!bvalid) @(negedge aclk);
    for (int k = 0; k < 3; k++) begin
      @(negedge aclk);
      chk("R7 bvalid held", 32'(bvalid), 1);
      chk("R7 ready low while bvalid", {30'b0, awready, wready}, 0);
    end
    bready = 1; @(negedge aclk); bready = 0;
    chk("R7 bvalid cleared", 32'(bvalid), 0);

    // R5 / R10 status read
    statIn = 32'h5A5A_0F0F;
    repeat (6) @(negedge aclk);
    doRead(32'h2004, rd, resp);
    chk("R5 status value", rd, 32'h5A5A_0F0F);
    chk("R5 status resp", 32'(resp), 0);
    repeat (12) @(negedge aclk);
    chk("R10 one status pulse", 32'(statPulses), 1);
    chk("R9 no extra control pulse", 32'(ctrlPulses), 32'(expCtrlPulses + 1));

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge aclk);
    nFail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule